// File: doc/BRIEF.md
# Machine-Cycle Reset Sequencer

This block produces the state and phase timing of a classic 8-bit controller whose machine cycle has six states with two phases each, twelve oscillator clocks in all. It also owns the internal reset. The external reset request is asynchronous and active high. It passes through a short synchronizer and is then looked at only once per machine cycle, in the second phase of the fifth state. Every change of the internal reset is therefore tied to the same point of the machine cycle.

When the request is seen, the internal reset rises and stays high for a fixed minimum number of machine cycles. It also stays high for as long as the request is held. Release is only recognised at a later sample slot. The block then gives a one-clock address-output-enable strobe in the next first phase of state five. ALE falls for the first time one phase after that strobe and then follows a fixed pattern locked to the counter. While the internal reset is high, the port outputs read as all ones and ALE is held high. The block has no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `mc_reset_seq`

## Requirements
- R1: After power-on clear (`por_n` low), the counter shows S1 P1 (`state`=1, `phase`=0). It advances one phase per clock through S1 P1, S1 P2, S2 P1 … S6 P2 (`phase` 0 is P1, 1 is P2) and wraps from S6 P2 back to S1 P1.
- R2: `rst_in` passes through a 2-stage synchronizer and is only acted on at the S5 P2 clock. `int_rst` can only rise in the clock that shows S6 P1. A request that is low at every sample slot has no effect on any output.
- R3: Once `int_rst` rises, it stays high for at least 2 machine cycles (24 clocks), even if `rst_in` was already released. A request held for 13 clocks gives exactly 24 clocks of `int_rst`.
- R4: `int_rst` stays high for as long as the synchronized `rst_in` is high at the sample slots.
- R5: Release is recognised at an S5 P2 sample slot. `int_rst` falls only in the clock that shows S6 P1.
- R6: After release, `addr_oe` is high for exactly one clock, in the next S5 P1, and is never high while `int_rst` is high.
- R7: `ale` is 1 while `int_rst` is high and until its first falling edge. That falling edge is in the S5 P2 that directly follows the `addr_oe` strobe.
- R8: In normal running, `ale` is 1 in S1 P2, S2 P1, S4 P2 and S5 P1 and 0 in all other slots, so it falls twice per machine cycle.
- R9: `port_out` is all ones while `int_rst` is high. Otherwise it equals `port_in`.
- R10: When the request has been held long enough to finish the reset procedure, the first ALE low is observed between 14 and 25 clocks after `rst_in` falls. That is at least one machine cycle plus the synchronizer delay, and less than two machine cycles plus that delay.
- R11: Power-on clear puts the block in reset. `int_rst` is 1 from the first clock, and the reset procedure starts its count from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per cycle |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| rst_in | input | 1 | External reset request, active high, asynchronous |
| port_in | input | PORT_W | Port data for normal operation |
| int_rst | output | 1 | Internal reset, active high |
| state | output | 3 | Current state number 1..6 |
| phase | output | 1 | Current phase, 0 = P1, 1 = P2 |
| addr_oe | output | 1 | One-clock strobe: address output starts |
| ale | output | 1 | Address latch enable |
| port_out | output | PORT_W | Port outputs, forced to all ones in reset |

## Verification
The bench uses the default parameters: six states, two phases, two synchronizer stages, a two-machine-cycle reset procedure and an 8-bit port. A machine cycle is then only twelve clocks. That makes it cheap to sweep the release of `rst_in` across every clock offset of the cycle, including both sides of the S5 P2 slot, and so reach both ends of the release-to-ALE window. The short procedure also lets random request pulses shorter and longer than 24 clocks land often enough to cover early release, long holds and re-entry from normal running.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Controller modes of the sequencer
  typedef enum logic [1:0] {
    MODE_RESET = 2'd0,  // internal reset held
    MODE_WAIT  = 2'd1,  // released, waiting for the fetch slot
    MODE_RUN   = 2'd2   // normal running
  } seq_mode_e;

  // Position of a (state, phase) pair inside the machine cycle, 1-based inputs
  function automatic int slot_pos(input int st, input int ph, input int n_ph);
    return (st - 1) * n_ph + (ph - 1);
  endfunction
endpackage

// File: rtl/rsq_phase_ctr.sv
module rsq_phase_ctr #(
  parameter int N_STATES = 6,
  parameter int N_PHASES = 2,
  localparam int POS_N = N_STATES * N_PHASES,
  localparam int POS_W = $clog2(POS_N),
  localparam int ST_W  = $clog2(N_STATES + 1),
  localparam int PH_W  = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic             clk,
  input  logic             por_n,
  output logic [POS_W-1:0] pos,
  output logic [ST_W-1:0]  state_num,
  output logic [PH_W-1:0]  phase_idx
);
  localparam int SI_W = (N_STATES > 1) ? $clog2(N_STATES) : 1;
  localparam logic [SI_W-1:0] ST_LAST = SI_W'(N_STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PHASES - 1);

  logic [SI_W-1:0] st_q;
  logic [PH_W-1:0] ph_q;

  // Free-running: only power-on clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q <= '0;
      ph_q <= '0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
      st_q <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  always_comb begin
    pos       = POS_W'(st_q) * POS_W'(N_PHASES) + POS_W'(ph_q);
    state_num = ST_W'(st_q) + 1'b1;
    phase_idx = ph_q;
  end
endmodule

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
#(
  parameter int RST_CYCLES = 2
) (
  input  logic      clk,
  input  logic      por_n,
  input  logic      at_sample,
  input  logic      at_fetch,
  input  logic      req_sync,
  output logic      int_rst,
  output logic      addr_oe,
  output logic      running
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(RST_CYCLES - 1);

  seq_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             proc_done;

  // Sample slots seen since entry: done once RST_CYCLES-1 further slots passed
  assign proc_done = (cnt_q >= CNT_DONE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_RESET;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_RESET: begin
          if (at_sample) begin
            if (proc_done && !req_sync) mode_q <= MODE_WAIT;
            else if (!proc_done)        cnt_q  <= cnt_q + 1'b1;
          end
        end
        MODE_WAIT: begin
          if (at_sample && req_sync) begin
            mode_q <= MODE_RESET;
            cnt_q  <= '0;
          end else if (at_fetch) begin
            mode_q <= MODE_RUN;
          end
        end
        MODE_RUN: begin
          if (at_sample && req_sync) begin
            mode_q <= MODE_RESET;
            cnt_q  <= '0;
          end
        end
        default: begin
          mode_q <= MODE_RESET;
          cnt_q  <= '0;
        end
      endcase
    end
  end

  always_comb begin
    int_rst = (mode_q == MODE_RESET);
    addr_oe = (mode_q == MODE_WAIT) && at_fetch;
    running = (mode_q == MODE_RUN);
  end
endmodule

// File: rtl/rsq_ale_gen.sv
module rsq_ale_gen #(
  parameter int POS_N  = 12,
  parameter int HI_A   = 1,
  parameter int HI_B   = 7,
  parameter int HI_LEN = 2,
  localparam int POS_W = $clog2(POS_N)
) (
  input  logic [POS_W-1:0] pos,
  input  logic             running,
  output logic             ale
);
  logic [1:0][HI_LEN-1:0] hit;

  generate
    for (genvar k = 0; k < HI_LEN; k++) begin : g_win
      assign hit[0][k] = (pos == POS_W'((HI_A + k) % POS_N));
      assign hit[1][k] = (pos == POS_W'((HI_B + k) % POS_N));
    end
  endgenerate

  // Held high outside normal running
  assign ale = running ? (|hit) : 1'b1;
endmodule

// File: rtl/mc_reset_seq.sv
module mc_reset_seq
  import rsq_pkg::*;
#(
  parameter int N_STATES     = 6,
  parameter int N_PHASES     = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_CYCLES   = 2,
  parameter int SAMPLE_STATE = 5,
  parameter int SAMPLE_PHASE = 2,
  parameter int FETCH_STATE  = 5,
  parameter int FETCH_PHASE  = 1,
  parameter int PORT_W       = 8,
  localparam int ST_W = $clog2(N_STATES + 1),
  localparam int PH_W = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_in,
  input  logic [PORT_W-1:0] port_in,
  output logic              int_rst,
  output logic [ST_W-1:0]   state,
  output logic [PH_W-1:0]   phase,
  output logic              addr_oe,
  output logic              ale,
  output logic [PORT_W-1:0] port_out
);
  localparam int POS_N      = N_STATES * N_PHASES;
  localparam int POS_W      = $clog2(POS_N);
  localparam int SAMPLE_POS = slot_pos(SAMPLE_STATE, SAMPLE_PHASE, N_PHASES);
  localparam int FETCH_POS  = slot_pos(FETCH_STATE, FETCH_PHASE, N_PHASES);
  // ALE windows: one ending at the fetch slot, one half a cycle earlier
  localparam int ALE_B      = FETCH_POS - 1;
  localparam int ALE_A      = (ALE_B + POS_N - POS_N / 2) % POS_N;

  logic [POS_W-1:0] pos;
  logic             req_sync;
  logic             at_sample;
  logic             at_fetch;
  logic             running;

  rsq_phase_ctr #(.N_STATES(N_STATES), .N_PHASES(N_PHASES)) u_ctr (
    .clk(clk), .por_n(por_n), .pos(pos), .state_num(state), .phase_idx(phase)
  );

  rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .por_n(por_n), .d_async(rst_in), .q_sync(req_sync)
  );

  assign at_sample = (pos == POS_W'(SAMPLE_POS));
  assign at_fetch  = (pos == POS_W'(FETCH_POS));

  rsq_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .por_n(por_n), .at_sample(at_sample), .at_fetch(at_fetch),
    .req_sync(req_sync), .int_rst(int_rst), .addr_oe(addr_oe), .running(running)
  );

  rsq_ale_gen #(.POS_N(POS_N), .HI_A(ALE_A), .HI_B(ALE_B), .HI_LEN(2)) u_ale (
    .pos(pos), .running(running), .ale(ale)
  );

  assign port_out = int_rst ? {PORT_W{1'b1}} : port_in;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int N_STATES   = 6,
  parameter int N_PHASES   = 2,
  parameter int RST_CYCLES = 2,
  parameter int PORT_W     = 8,
  localparam int ST_W = $clog2(N_STATES + 1),
  localparam int PH_W = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input logic              clk,
  input logic              por_n,
  input logic              int_rst,
  input logic [ST_W-1:0]   state,
  input logic [PH_W-1:0]   phase,
  input logic              addr_oe,
  input logic              ale,
  input logic [PORT_W-1:0] port_out
);
  localparam int MIN_HI = RST_CYCLES * N_STATES * N_PHASES;

  logic [15:0] hi_cnt;
  logic        armed;

  // Length of a reset episode that started from a rise (not power-on)
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else if (int_rst) begin
      if (!armed && hi_cnt == 16'd0) hi_cnt <= 16'd0;
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end else begin
      hi_cnt <= '0;
      armed  <= 1'b1;
    end
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_W'(N_STATES) && phase == PH_W'(N_PHASES - 1)) |=>
    (state == ST_W'(1) && phase == '0));

  p_rise_slot_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(int_rst) |-> (state == ST_W'(6) && phase == '0));

  p_fall_slot_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(int_rst) |-> (state == ST_W'(6) && phase == '0));

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(int_rst) && armed) |-> (hi_cnt >= 16'(MIN_HI)));

  p_oe_slot_r6: assert property (@(posedge clk) disable iff (!por_n)
    addr_oe |-> (!int_rst && state == ST_W'(5) && phase == '0));

  p_oe_single_r6: assert property (@(posedge clk) disable iff (!por_n)
    addr_oe |=> !addr_oe);

  p_ale_first_r7: assert property (@(posedge clk) disable iff (!por_n)
    addr_oe |=> !ale);

  p_ale_rst_r7: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> ale);

  p_port_ones_r9: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> (port_out == {PORT_W{1'b1}}));
endmodule

bind mc_reset_seq rsq_checker #(
  .N_STATES(N_STATES), .N_PHASES(N_PHASES), .RST_CYCLES(RST_CYCLES), .PORT_W(PORT_W)
) u_rsq_chk (
  .clk(clk), .por_n(por_n), .int_rst(int_rst), .state(state), .phase(phase),
  .addr_oe(addr_oe), .ale(ale), .port_out(port_out)
);

// File: tb/tb_mc_reset_seq.sv
module tb_mc_reset_seq;
  localparam int MC = 12;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_in = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic       int_rst, addr_oe, ale, phase;
  logic [2:0] state;
  logic [7:0] port_out;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int wd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mc_reset_seq dut (
    .clk(clk), .por_n(por_n), .rst_in(rst_in), .port_in(port_in),
    .int_rst(int_rst), .state(state), .phase(phase), .addr_oe(addr_oe),
    .ale(ale), .port_out(port_out)
  );

  // Reference model built from the requirements
  logic [1:0] m_sync;
  int m_pos, m_mode, m_cnt;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_sync <= 2'b11; m_pos <= 0; m_mode <= 0; m_cnt <= 0;
    end else begin
      m_sync <= {m_sync[0], rst_in};
      m_pos  <= (m_pos == MC - 1) ? 0 : m_pos + 1;
      case (m_mode)
        0: if (m_pos == 9) begin
             if (m_cnt >= 1 && !m_sync[1]) m_mode <= 1;
             else if (m_cnt < 1) m_cnt <= m_cnt + 1;
           end
        1: if (m_pos == 9 && m_sync[1]) begin m_mode <= 0; m_cnt <= 0; end
           else if (m_pos == 8) m_mode <= 2;
        default: if (m_pos == 9 && m_sync[1]) begin m_mode <= 0; m_cnt <= 0; end
      endcase
    end
  end

  function automatic logic exp_ale(int mode, int pos);
    if (mode != 2) return 1'b1;
    return (pos == 1 || pos == 2 || pos == 7 || pos == 8);
  endfunction

  function automatic logic [7:0] exp_port(int mode, logic [7:0] pin);
    return (mode == 0) ? 8'hFF : pin;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Latency / pulse bookkeeping
  logic prev_ale = 1'b1;
  logic prev_rst = 1'b1;
  int   rel_cyc = 0;
  bit   lat_armed = 0;
  int   hi_len = 0;
  int   oe_count = 0;

  task automatic step();
    @(negedge clk);
    cyc++;
    check("R1 state", 32'(state), 32'(m_pos / 2 + 1));
    check("R1 phase", 32'(phase), 32'(m_pos % 2));
    check("R2/R3/R4/R5 int_rst", 32'(int_rst), 32'(m_mode == 0));
    check("R6 addr_oe", 32'(addr_oe), 32'(m_mode == 1 && m_pos == 8));
    check("R7/R8 ale", 32'(ale), 32'(exp_ale(m_mode, m_pos)));
    check("R9 port_out", 32'(port_out), 32'(exp_port(m_mode, port_in)));
    if (addr_oe) oe_count++;
    if (int_rst) hi_len++;
    if (lat_armed && prev_ale && !ale) begin
      total++;
      if (cyc - rel_cyc < 14 || cyc - rel_cyc > 25) begin
        fails++;
        $display("FAIL R10 latency act=%0d exp=14..25", cyc - rel_cyc);
      end
      lat_armed = 0;
    end
    prev_ale = ale;
    prev_rst = int_rst;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_run();
    int guard = 0;
    while ((int_rst || ale == 1'b1 && m_mode != 2) && guard < 200) begin
      step(); guard++;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      fails++; total++;
      $display("FAIL watchdog (all) act=%0d exp<150000", wd);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R11 / R1 reset state
    #2;
    check("R11 int_rst at power-on", 32'(int_rst), 32'd1);
    check("R1 state at power-on", 32'(state), 32'd1);
    check("R1 phase at power-on", 32'(phase), 32'd0);
    check("R7 ale at power-on", 32'(ale), 32'd1);
    check("R9 port at power-on", 32'(port_out), 32'hFF);
    #20 por_n = 1'b1;
    port_in = 8'h5A;
    steps(3);
    wait_run();
    steps(2 * MC);

    // R3: 13-clock request from running gives exactly 24 clocks of reset
    for (int rep = 0; rep < 4; rep++) begin
      steps(rep * 3);
      rst_in = 1'b1;
      hi_len = 0;
      steps(13);
      rst_in = 1'b0;
      steps(4 * MC);
      check("R3 short request hold length", 32'(hi_len), 32'(2 * MC));
    end

    // R2: a pulse that misses the sample slot is ignored
    while (m_pos != 11) step();
    rst_in = 1'b1; step(); rst_in = 1'b0;
    hi_len = 0;
    steps(2 * MC);
    check("R2 missed pulse ignored", 32'(hi_len), 32'd0);

    // R4 + R10 + R6: long hold then release at every offset of the cycle
    for (int off = 0; off < MC; off++) begin
      rst_in = 1'b1;
      steps(60);
      check("R4 still in reset while held", 32'(int_rst), 32'd1);
      steps(off);
      rst_in = 1'b0;
      rel_cyc = cyc;
      lat_armed = 1;
      oe_count = 0;
      steps(3 * MC);
      check("R10 first ALE low seen", 32'(lat_armed), 32'd0);
      check("R6 single fetch strobe", 32'(oe_count), 32'd1);
    end

    // Random request pulses and port data
    for (int it = 0; it < 300; it++) begin
      rst_in = $urandom_range(0, 1);
      port_in = 8'($urandom);
      steps($urandom_range(1, 40));
    end
    rst_in = 1'b0;
    steps(4 * MC);
    check("R6/R7 running after random phase", 32'(int_rst), 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule